// File: doc/BRIEF.md
# Warp Control Unit

This block carries out the warp-control operations of a multi-warp SIMT core that has W warps of N lanes each. It holds one state slot per warp. Each slot has an active flag, a lane-enable mask, a start PC and a supervisor bit. The execute stage hands the block one operation per cycle: a 3-bit sub-op code, the id of the issuing warp, and the two source operand values of that warp's lane 0. These instructions run on lane 0 only, so the other lanes' operands never reach the block.

Three sub-ops have an effect:

- **Set-lane-mask** rewrites the mask of the issuing warp to a lane count. A count of zero retires the warp.
- **Spawn** launches warps 1 to count-1. Each launched warp starts at a common PC, in user mode, with only lane 0 enabled.
- **Barrier** is accepted but performs nothing here.

Split and join belong to another unit. They, and all unused codes, leave the state untouched. Out-of-range counts are clamped, and they raise a one-cycle error pulse.

The block also answers two read-only CSR addresses:

- 0x020 returns the querying lane's index.
- 0x021 returns the querying warp's id.

The scheduler and the fetch stage read the per-warp state from the flattened output buses.

Top module: `warp_ctl`

## Requirements
- R1: After reset, warp 0 is active with mask 1 (lane 0 only), PC = BOOT_PC and supervisor bit 1. Every other warp is inactive with mask 0, PC 0 and supervisor bit 0, and err_o is 0.
- R2: Set-lane-mask (sub-op 0) with count c in 1..N sets the issuing warp's mask to lanes 0..c-1 and keeps it active. No other warp changes, and the warp's PC and supervisor bit do not change.
- R3: Set-lane-mask with count 0 clears the issuing warp's active flag and its mask.
- R4: Set-lane-mask with count greater than N enables all N lanes, keeps the warp active and raises err_o.
- R5: Spawn (sub-op 1) with count c (first operand) sets warp k, for every 1 <= k < min(c,W), to: active, mask 1, PC = second operand, supervisor 0. Warp 0 and warps at or above c are unchanged.
- R6: Spawn with a count greater than W behaves as a count of W and raises err_o.
- R7: Sub-ops 2 (split), 3 (join), 4 (barrier) and the unused codes 5 to 7 change no warp state and raise no error.
- R8: The CSR read is combinational. Address 0x020 returns csr_lane_i and address 0x021 returns csr_wid_i, each zero-extended, with csr_hit_o = 1. Any other address returns 0 with csr_hit_o = 0.
- R9: err_o is high in exactly the cycle after an accepted erroring operation (R4 or R6) and low otherwise.
- R10: While op_valid_i is 0, no warp state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| op_valid_i | input | 1 | operation present this cycle |
| op_sub_i | input | 3 | sub-op code: 0 lane mask, 1 spawn, 2 split, 3 join, 4 barrier |
| op_wid_i | input | clog2(W) | issuing warp id |
| op_src_a_i | input | XLEN | lane-0 first operand: the count |
| op_src_b_i | input | XLEN | lane-0 second operand: the spawn PC |
| csr_addr_i | input | 12 | CSR read address |
| csr_lane_i | input | clog2(N) | lane index of the reader |
| csr_wid_i | input | clog2(W) | warp id of the reader |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_hit_o | output | 1 | address is one of the two implemented CSRs |
| warp_active_o | output | W | active flag per warp |
| warp_tmask_o | output | W*N | lane mask; warp w at bits [w*N +: N] |
| warp_pc_o | output | W*XLEN | start PC; warp w at bits [w*XLEN +: XLEN] |
| warp_super_o | output | W | supervisor bit per warp |
| err_o | output | 1 | one-cycle error pulse after an out-of-range count |

## Verification
The assertions check on every cycle the properties that follow from a single operation:

- retire on a zero count (R3) and the all-lanes result of an oversized count (R4);
- the contents of the first spawned warp (R5);
- the fact that idle cycles and the passive sub-ops leave the state frozen (R7, R10);
- the cause behind every error pulse (R9);
- the CSR decode (R8).

Only the bench's sweeps show the rest:

- the exact thermometer mask for each count and each warp (R2);
- the full set of warps that a spawn touches, up to and including the clamp (R5, R6);
- the lack of side effects on warps that were not addressed.

// File: rtl/warp_ctl_pkg.sv
package warp_ctl_pkg;
  typedef enum logic [2:0] {
    SUB_TMASK = 3'd0,
    SUB_SPAWN = 3'd1,
    SUB_SPLIT = 3'd2,
    SUB_JOIN  = 3'd3,
    SUB_BAR   = 3'd4
  } sub_op_e;

  localparam logic [11:0] CSR_LANE_ID = 12'h020;
  localparam logic [11:0] CSR_WARP_ID = 12'h021;
endpackage

// File: rtl/warp_ctl_dec.sv
module warp_ctl_dec
  import warp_ctl_pkg::*;
#(
  parameter int W    = 4,
  parameter int N    = 4,
  parameter int XLEN = 32
) (
  input  logic            valid_i,
  input  logic [2:0]      sub_i,
  input  logic [XLEN-1:0] cnt_i,
  output logic            tm_we_o,
  output logic [N-1:0]    tm_mask_o,
  output logic            tm_live_o,
  output logic [W-1:0]    spawn_sel_o,
  output logic            err_o
);
  logic is_tm, is_sp;

  always_comb begin
    is_tm = valid_i && (sub_i == SUB_TMASK);
    is_sp = valid_i && (sub_i == SUB_SPAWN);
    tm_we_o   = is_tm;
    tm_live_o = (cnt_i != '0);
    // thermometer: lane j enabled when j < count (saturates at N)
    for (int j = 0; j < N; j++) tm_mask_o[j] = (cnt_i > XLEN'(j));
    // warps 1..count-1; a count above W selects all, so the clamp is implicit
    spawn_sel_o[0] = 1'b0;
    for (int i = 1; i < W; i++) spawn_sel_o[i] = is_sp && (cnt_i > XLEN'(i));
    err_o = (is_tm && (cnt_i > XLEN'(N))) || (is_sp && (cnt_i > XLEN'(W)));
  end
endmodule

// File: rtl/warp_ctl_slot.sv
module warp_ctl_slot #(
  parameter int              N       = 4,
  parameter int              XLEN    = 32,
  parameter int              IDX     = 0,
  parameter logic [XLEN-1:0] BOOT_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            spawn_i,
  input  logic [XLEN-1:0] spawn_pc_i,
  input  logic            tm_we_i,
  input  logic [N-1:0]    tm_mask_i,
  input  logic            tm_live_i,
  output logic            active_o,
  output logic [N-1:0]    tmask_o,
  output logic [XLEN-1:0] pc_o,
  output logic            super_o
);
  localparam bit               BOOT    = (IDX == 0);
  localparam logic [N-1:0]     RST_TM  = BOOT ? N'(1) : '0;
  localparam logic [XLEN-1:0]  RST_PC  = BOOT ? BOOT_PC : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= BOOT;
      tmask_o  <= RST_TM;
      pc_o     <= RST_PC;
      super_o  <= BOOT;
    end else if (spawn_i) begin
      active_o <= 1'b1;
      tmask_o  <= N'(1);
      pc_o     <= spawn_pc_i;
      super_o  <= 1'b0;
    end else if (tm_we_i) begin
      active_o <= tm_live_i;
      tmask_o  <= tm_mask_i;
    end
  end
endmodule

// File: rtl/warp_ctl_csr.sv
module warp_ctl_csr
  import warp_ctl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LW   = 2,
  parameter int WW   = 2
) (
  input  logic [11:0]     addr_i,
  input  logic [LW-1:0]   lane_i,
  input  logic [WW-1:0]   wid_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            hit_o
);
  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    unique case (addr_i)
      CSR_LANE_ID: begin rdata_o = XLEN'(lane_i); hit_o = 1'b1; end
      CSR_WARP_ID: begin rdata_o = XLEN'(wid_i);  hit_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/warp_ctl.sv
module warp_ctl #(
  parameter int              W       = 4,
  parameter int              N       = 4,
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] BOOT_PC = 32'h0000_1000,
  localparam int             WW      = (W > 1) ? $clog2(W) : 1,
  localparam int             LW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_sub_i,
  input  logic [WW-1:0]     op_wid_i,
  input  logic [XLEN-1:0]   op_src_a_i,
  input  logic [XLEN-1:0]   op_src_b_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [LW-1:0]     csr_lane_i,
  input  logic [WW-1:0]     csr_wid_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_hit_o,
  output logic [W-1:0]      warp_active_o,
  output logic [W*N-1:0]    warp_tmask_o,
  output logic [W*XLEN-1:0] warp_pc_o,
  output logic [W-1:0]      warp_super_o,
  output logic              err_o
);
  logic         tm_we, tm_live, dec_err;
  logic [N-1:0] tm_mask;
  logic [W-1:0] spawn_sel;

  warp_ctl_dec #(.W(W), .N(N), .XLEN(XLEN)) u_dec (
    .valid_i     (op_valid_i),
    .sub_i       (op_sub_i),
    .cnt_i       (op_src_a_i),
    .tm_we_o     (tm_we),
    .tm_mask_o   (tm_mask),
    .tm_live_o   (tm_live),
    .spawn_sel_o (spawn_sel),
    .err_o       (dec_err)
  );

  for (genvar w = 0; w < W; w++) begin : g_slot
    logic sel;
    assign sel = tm_we && (op_wid_i == WW'(w));
    warp_ctl_slot #(.N(N), .XLEN(XLEN), .IDX(w), .BOOT_PC(BOOT_PC)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .spawn_i    (spawn_sel[w]),
      .spawn_pc_i (op_src_b_i),
      .tm_we_i    (sel),
      .tm_mask_i  (tm_mask),
      .tm_live_i  (tm_live),
      .active_o   (warp_active_o[w]),
      .tmask_o    (warp_tmask_o[w*N +: N]),
      .pc_o       (warp_pc_o[w*XLEN +: XLEN]),
      .super_o    (warp_super_o[w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= dec_err;
  end

  warp_ctl_csr #(.XLEN(XLEN), .LW(LW), .WW(WW)) u_csr (
    .addr_i  (csr_addr_i),
    .lane_i  (csr_lane_i),
    .wid_i   (csr_wid_i),
    .rdata_o (csr_rdata_o),
    .hit_o   (csr_hit_o)
  );
endmodule

// File: rtl/warp_ctl_chk.sv
module warp_ctl_chk #(
  parameter int W    = 4,
  parameter int N    = 4,
  parameter int XLEN = 32,
  parameter int WW   = 2,
  parameter int LW   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [2:0]        op_sub_i,
  input logic [WW-1:0]     op_wid_i,
  input logic [XLEN-1:0]   op_src_a_i,
  input logic [XLEN-1:0]   op_src_b_i,
  input logic [11:0]       csr_addr_i,
  input logic [LW-1:0]     csr_lane_i,
  input logic [WW-1:0]     csr_wid_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              csr_hit_o,
  input logic [W-1:0]      warp_active_o,
  input logic [W*N-1:0]    warp_tmask_o,
  input logic [W*XLEN-1:0] warp_pc_o,
  input logic [W-1:0]      warp_super_o,
  input logic              err_o
);
  p_retire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_sub_i == 3'd0 && op_src_a_i == '0) |=>
      (!warp_active_o[$past(op_wid_i)] && warp_tmask_o[$past(op_wid_i)*N +: N] == '0));

  p_overcount_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_sub_i == 3'd0 && op_src_a_i > XLEN'(N)) |=>
      (err_o && warp_active_o[$past(op_wid_i)] && (&warp_tmask_o[$past(op_wid_i)*N +: N])));

  if (W > 1) begin : g_sp
    p_spawn_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sub_i == 3'd1 && op_src_a_i > XLEN'(1)) |=>
        (warp_active_o[1] && warp_tmask_o[N +: N] == N'(1) && !warp_super_o[1]
         && warp_pc_o[XLEN +: XLEN] == $past(op_src_b_i)));
  end

  p_passive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_sub_i >= 3'd2) |=>
      ($stable(warp_active_o) && $stable(warp_tmask_o) && $stable(warp_pc_o)
       && $stable(warp_super_o) && !err_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=>
      ($stable(warp_active_o) && $stable(warp_tmask_o) && $stable(warp_pc_o)
       && $stable(warp_super_o)));

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(op_valid_i && ((op_sub_i == 3'd0 && op_src_a_i > XLEN'(N))
                                || (op_sub_i == 3'd1 && op_src_a_i > XLEN'(W)))));

  p_boot_super_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(warp_super_o[0]));

  p_csr_lane_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == 12'h020) |-> (csr_hit_o && csr_rdata_o == XLEN'(csr_lane_i)));

  p_csr_wid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == 12'h021) |-> (csr_hit_o && csr_rdata_o == XLEN'(csr_wid_i)));

  p_csr_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i != 12'h020 && csr_addr_i != 12'h021) |-> (!csr_hit_o && csr_rdata_o == '0));
endmodule

bind warp_ctl warp_ctl_chk #(.W(W), .N(N), .XLEN(XLEN), .WW(WW), .LW(LW)) u_chk (.*);

// File: tb/warp_ctl_test.sv
`timescale 1ns/1ps
module warp_ctl_test;
  localparam int          W    = 4;
  localparam int          N    = 4;
  localparam int          XLEN = 32;
  localparam logic [31:0] BOOT = 32'h0000_1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_valid = 1'b0;
  logic [2:0]        op_sub = '0;
  logic [1:0]        op_wid = '0;
  logic [31:0]       op_a = '0, op_b = '0;
  logic [11:0]       csr_addr = '0;
  logic [1:0]        csr_lane = '0, csr_wid = '0;
  logic [31:0]       csr_rdata;
  logic              csr_hit;
  logic [W-1:0]      w_act, w_sup;
  logic [W*N-1:0]    w_tm;
  logic [W*XLEN-1:0] w_pc;
  logic              err;

  always #4 clk = ~clk;

  warp_ctl #(.W(W), .N(N), .XLEN(XLEN), .BOOT_PC(BOOT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_sub_i(op_sub),
    .op_wid_i(op_wid), .op_src_a_i(op_a), .op_src_b_i(op_b),
    .csr_addr_i(csr_addr), .csr_lane_i(csr_lane), .csr_wid_i(csr_wid),
    .csr_rdata_o(csr_rdata), .csr_hit_o(csr_hit),
    .warp_active_o(w_act), .warp_tmask_o(w_tm), .warp_pc_o(w_pc),
    .warp_super_o(w_sup), .err_o(err)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  bit          m_act[W];
  bit          m_sup[W];
  logic [N-1:0] m_tm[W];
  logic [31:0] m_pc[W];
  bit          m_err;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int w = 0; w < W; w++) begin
      chk(tag, $sformatf("active[%0d]", w), 64'(w_act[w]), 64'(m_act[w]));
      chk(tag, $sformatf("tmask[%0d]", w),  64'(w_tm[w*N +: N]), 64'(m_tm[w]));
      chk(tag, $sformatf("pc[%0d]", w),     64'(w_pc[w*XLEN +: XLEN]), 64'(m_pc[w]));
      chk(tag, $sformatf("super[%0d]", w),  64'(w_sup[w]), 64'(m_sup[w]));
    end
    chk("R9", {tag, " err"}, 64'(err), 64'(m_err));
  endtask

  task automatic model_reset();
    for (int w = 0; w < W; w++) begin
      m_act[w] = (w == 0);
      m_sup[w] = (w == 0);
      m_tm[w]  = (w == 0) ? N'(1) : '0;
      m_pc[w]  = (w == 0) ? BOOT : '0;
    end
    m_err = 1'b0;
  endtask

  task automatic issue(input string tag, input bit v, input logic [2:0] s,
                       input int wid, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = v; op_sub = s; op_wid = 2'(wid); op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    m_err = 1'b0;
    if (v && s == 3'd0) begin
      if (a == 0) begin m_act[wid] = 1'b0; m_tm[wid] = '0; end
      else begin
        m_act[wid] = 1'b1;
        m_tm[wid]  = (a >= N) ? {N{1'b1}} : N'((1 << a) - 1);
      end
      m_err = (a > N);
    end else if (v && s == 3'd1) begin
      int lim;
      lim = (a > W) ? W : int'(a);
      for (int k = 1; k < lim; k++) begin
        m_act[k] = 1'b1; m_tm[k] = N'(1); m_pc[k] = b; m_sup[k] = 1'b0;
      end
      m_err = (a > W);
    end
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // R2/R3/R4: lane-mask counts 0..6 on every warp
    for (int w = 0; w < W; w++)
      for (int c = 0; c <= 6; c++)
        issue(c == 0 ? "R3" : (c > N ? "R4" : "R2"), 1'b1, 3'd0, w, 32'(c), 32'hdead_0000);
    issue("R4", 1'b1, 3'd0, 2, 32'hffff_ffff, 32'h0);

    // R5/R6: spawn counts 0..6 with distinct PCs
    for (int c = 0; c <= 6; c++)
      issue(c > W ? "R6" : "R5", 1'b1, 3'd1, c % W, 32'(c), 32'h0000_2000 + 32'(c * 16));
    issue("R6", 1'b1, 3'd1, 3, 32'h8000_0000, 32'h0000_3000);
    issue("R2", 1'b1, 3'd0, 1, 32'd3, 32'h0);

    // R7: split, join, barrier and unused codes change nothing
    for (int s = 2; s <= 7; s++)
      for (int w = 0; w < W; w++)
        issue("R7", 1'b1, 3'(s), w, 32'(s + w), 32'h0000_4000);

    // R10: invalid operations are ignored, even ones that would retire or spawn
    issue("R10", 1'b0, 3'd0, 1, 32'd0, 32'h0);
    issue("R10", 1'b0, 3'd1, 0, 32'd9, 32'h0000_5000);
    issue("R10", 1'b0, 3'd0, 0, 32'd7, 32'h0);

    // R8: CSR sweep
    for (int ad = 12'h01e; ad <= 12'h023; ad++)
      for (int l = 0; l < N; l++)
        for (int w = 0; w < W; w++) begin
          logic [31:0] ed;
          @(negedge clk);
          csr_addr = 12'(ad); csr_lane = 2'(l); csr_wid = 2'(w);
          #1;
          ed = (ad == 12'h020) ? 32'(l) : (ad == 12'h021) ? 32'(w) : 32'h0;
          chk("R8", "csr_rdata", 64'(csr_rdata), 64'(ed));
          chk("R8", "csr_hit", 64'(csr_hit), 64'(ad == 12'h020 || ad == 12'h021));
        end

    // R1: reset again mid-run restores boot state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check_state("R1");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule